// File: doc/BRIEF.md
# Scanline Framebuffer Pixel Fetcher

This block reads one row of a byte-wide framebuffer from an external asynchronous SRAM and plays it out as the visible part of a video scanline. A one-cycle line-start strobe latches the row number into the upper address bits and clears the column address. After a fixed lead-in, a window of active video opens. Inside it the column address advances on a fixed pixel period counted in clocks, and each returned byte goes unchanged to an 8-bit video output.

The pixel count per line is chosen at each line start. A narrow setting gives 16 wide pixels and a full setting gives 256 pixels. The pixel period is the active length divided by the pixel count, rounded down. Any cycles left over after the last pixel keep showing that pixel until the window closes. Outside the window the video output is zero and the column address stays where it is. The read byte is captured only after a parameterised number of whole clock cycles has passed since the last address change, so the memory's access time is respected.

Top module: `scan_fetch`

## Requirements
- R1: After reset `mem_addr` and `vid` are both zero.
- R2: On the edge where `line_start` is high, `row` is captured into `mem_addr[14:8]`. Those bits then keep that value until the next line start, whatever `row` does.
- R3: From the line-start edge to the opening of the window, `mem_addr[7:0]` is zero and `vid` is zero.
- R4: The window opens on the 872nd clock edge after the line-start edge. The column then advances by one every P cycles. P is 263 when `wide_px` was 1 at line start (16 pixels) and 16 when it was 0 (256 pixels).
- R5: `vid` is updated once per pixel with the unchanged `mem_rdata` byte. This happens on the edge exactly ACCESS_CYC+1 (default 3) cycles after the edge that set that pixel's address.
- R6: After the last pixel (column 15 or 255) the column holds there, and `vid` holds the last pixel's byte until the window ends.
- R7: The window lasts 4208 cycles. From the edge that closes it, `vid` is zero and the column does not change until the next line start.
- R8: A line start during the lead-in or the window abandons the current line and begins a new one at once, with `vid` back to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_start | input | 1 | One-cycle strobe marking the start of a scanline |
| wide_px | input | 1 | 1 = 16 pixels per line, 0 = 256 pixels per line; sampled with line_start |
| row | input | 7 | Framebuffer row for the coming line; sampled with line_start |
| mem_rdata | input | 8 | Read data from the SRAM |
| mem_addr | output | 15 | SRAM address: row in [14:8], column in [7:0] |
| vid | output | 8 | Video byte |

## Verification
The reference counts clock edges from the line-start edge, which is edge 0. The column address is due on edge 872 + k·P. Pixel k's byte is due on edge 872 + k·P + 3. Video falls to zero on edge 872 + 4208. After every edge the bench compares both outputs with these formulas at the following falling edge. Its memory model returns a garbage byte until three cycles after each address change, so a capture one cycle early shows up as wrong video rather than passing unnoticed.

// File: rtl/scan_fetch.sv
module scan_fetch #(
  parameter int ROW_W      = 7,
  parameter int COL_W      = 8,
  parameter int PIX_W      = 8,
  parameter int LEAD_CYC   = 872,
  parameter int ACTIVE_CYC = 4208,
  parameter int ACCESS_CYC = 2,
  parameter int NARROW_PIX = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   line_start,
  input  logic                   wide_px,
  input  logic [ROW_W-1:0]       row,
  input  logic [PIX_W-1:0]       mem_rdata,
  output logic [ROW_W+COL_W-1:0] mem_addr,
  output logic [PIX_W-1:0]       vid
);
  localparam int FULL_PIX = 1 << COL_W;
  localparam int PER_FULL = ACTIVE_CYC / FULL_PIX;
  localparam int PER_NARR = ACTIVE_CYC / NARROW_PIX;
  localparam int CNT_W    = $clog2(LEAD_CYC + ACTIVE_CYC + 1);

  typedef enum logic [1:0] {IDLE, LEAD, ACT} st_t;

  st_t              st;
  logic [CNT_W-1:0] cnt, ph;
  logic [COL_W-1:0] col;
  logic [ROW_W-1:0] row_q;
  logic             narrow_q, done;

  wire [CNT_W-1:0] per      = narrow_q ? CNT_W'(PER_NARR) : CNT_W'(PER_FULL);
  wire [COL_W-1:0] last_col = narrow_q ? COL_W'(NARROW_PIX - 1) : COL_W'(FULL_PIX - 1);
  wire             grab     = (st == ACT) && !done && (ph == CNT_W'(ACCESS_CYC));
  wire             closing  = (st == ACT) && (cnt == CNT_W'(ACTIVE_CYC - 1));

  assign mem_addr = {row_q, col};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= IDLE; cnt <= '0; ph <= '0; col <= '0; row_q <= '0;
      narrow_q <= 1'b0; done <= 1'b0; vid <= '0;
    end else if (line_start) begin
      st <= LEAD; cnt <= '0; ph <= '0; col <= '0; row_q <= row;
      narrow_q <= wide_px; done <= 1'b0; vid <= '0;
    end else begin
      case (st)
        LEAD: begin
          if (cnt == CNT_W'(LEAD_CYC - 1)) begin
            st <= ACT; cnt <= '0; ph <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ACT: begin
          cnt <= cnt + 1'b1;
          if (closing) begin
            st <= IDLE; vid <= '0;
          end else begin
            if (grab) vid <= mem_rdata;
            if (ph == per - 1'b1) begin
              ph <= '0;
              if (col == last_col) done <= 1'b1;
              else if (!done) col <= col + 1'b1;
            end else begin
              ph <= ph + 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  // R7
  blank_outside_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st != ACT) |-> (vid == '0));

  // R3
  col_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_start |=> (col == '0 && vid == '0));

  // R2
  row_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !line_start |=> $stable(mem_addr[ROW_W+COL_W-1:COL_W]));

  // R4
  col_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !line_start |=> (col == $past(col) || col == $past(col) + 1'b1));

  // R5
  vid_when_grab_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!line_start && !grab && !closing) |=> $stable(vid));

  // R6
  last_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (col == last_col));
endmodule

// File: tb/tb_scan_fetch.sv
module tb_scan_fetch;
  localparam int LEAD = 872, ACTV = 4208, ACC = 2;
  localparam int LINE = LEAD + ACTV + 4;
  // {row[15:9], wide[8], seed[7:0]}
  localparam logic [15:0] VEC [4] = '{
    {7'h00, 1'b1, 8'h00}, {7'h05, 1'b0, 8'h3C},
    {7'h7F, 1'b1, 8'hA5}, {7'h2A, 1'b0, 8'hFF}};

  logic clk = 0, rst_n = 0, line_start = 0, wide_px = 0;
  logic [6:0] row = 0;
  logic [7:0] mem_rdata, seed = 0, age = 8'hFF;
  logic [14:0] mem_addr, last_addr = 0;
  logic [7:0] vid;
  int tests = 0, fails = 0;
  int bad [9], used [9], act_v [9], exp_v [9];

  scan_fetch dut (.clk(clk), .rst_n(rst_n), .line_start(line_start), .wide_px(wide_px),
                  .row(row), .mem_rdata(mem_rdata), .mem_addr(mem_addr), .vid(vid));

  always #2.5 clk = ~clk;

  function automatic logic [7:0] pat(input logic [14:0] a);
    return a[7:0] ^ {a[14:8], 1'b0} ^ seed;
  endfunction

  // memory model: garbage until ACC+1 cycles after an address change
  always @(negedge clk) begin
    if (mem_addr != last_addr) age <= 8'd1;
    else if (age != 8'hFF) age <= age + 8'd1;
    last_addr <= mem_addr;
  end
  assign mem_rdata = (age > 8'(ACC)) ? pat(mem_addr) : 8'hE5;

  task automatic check(input string r, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic note(input int r, input int act, input int exp);
    used[r] = 1;
    if (act != exp && bad[r] == 0) begin act_v[r] = act; exp_v[r] = exp; end
    if (act != exp) bad[r]++;
  endtask

  task automatic run_line(input logic [6:0] r, input logic nar, input logic [7:0] s,
                          input int ncyc);
    int per, last, m, k;
    per  = nar ? 263 : 16;
    last = nar ? 15 : 255;
    for (int i = 0; i < 9; i++) begin bad[i] = 0; used[i] = 0; end
    @(negedge clk);
    seed = s; row = r; wide_px = nar; line_start = 1;
    for (int n = 0; n < ncyc; n++) begin
      @(posedge clk);
      @(negedge clk);
      line_start = 0;
      m = n - LEAD;
      note(2, mem_addr[14:8], r);
      if (m < 0) begin
        note(3, mem_addr[7:0], 0);
        note(3, vid, 0);
      end else if (m < ACTV) begin
        k = m / per; if (k > last) k = last;
        if (m < last * per + ACC + 1) begin
          note(4, mem_addr[7:0], k);
          note(5, vid, (m < ACC + 1) ? 0 : pat({r, 8'((m - ACC - 1) / per)}));
        end else begin
          note(6, mem_addr[7:0], last);
          note(6, vid, pat({r, 8'(last)}));
        end
      end else begin
        note(7, mem_addr[7:0], last);
        note(7, vid, 0);
      end
      if (n == 1000) row = ~r;
    end
    for (int i = 2; i < 8; i++)
      if (used[i] != 0) check($sformatf("R%0d", i), act_v[i] | (bad[i] << 16), exp_v[i]);
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk); cyc++;
      if (cyc > 150000) begin
        fails++; tests++;
        $display("FAIL watchdog actual=%0d expected<150000", cyc);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 addr", mem_addr, 0);
    check("R1 vid", vid, 0);
    rst_n = 1;
    repeat (5) @(negedge clk);
    check("R1 idle vid", vid, 0);

    for (int v = 0; v < 4; v++)
      run_line(VEC[v][15:9], VEC[v][8], VEC[v][7:0], LINE);

    // R8: abort mid-window, restart with different settings
    run_line(7'h11, 1'b0, 8'h5A, 2500);
    check("R8 vid live before restart", int'(vid != 0), 1);
    run_line(7'h12, 1'b1, 8'h66, LINE);
    check("R8 restarted line clean", bad[4] + bad[5] + bad[6] + bad[7], 0);

    // R8: restart during lead-in
    run_line(7'h01, 1'b0, 8'h10, 300);
    run_line(7'h40, 1'b0, 8'h99, LINE);
    check("R8 restart in lead-in", bad[3] + bad[5] + bad[7], 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule